// File: doc/BRIEF.md
# Stream-to-Memory Write Engine

This block receives one transfer command at a time and moves a packet stream into memory. The command gives a destination address, a byte limit and a flag that selects whether an end-of-packet marker stops the transfer. The engine accepts 512-bit stream beats that carry start, end and empty sideband. It turns each accepted beat into one 64-byte memory write with byte enables. It stops at the byte limit, or at the first end-of-packet if the flag is set, whichever comes first.

After the last write, the engine waits until every write response has returned from memory. It then gives a one-cycle completion pulse with the number of bytes actually stored and a flag that says whether an end-of-packet was taken. Software can use this to learn the length of a packet whose size it did not know in advance.

Control is a four-state machine:
- **IDLE**: waits for a command. A zero limit goes to FLUSH, any other limit goes to XFER.
- **XFER**: accepts beats and issues writes. It goes to FLUSH on the beat that ends the transfer.
- **FLUSH**: waits until the last write has left and no responses are still due. It then goes to REPORT.
- **REPORT**: pulses completion and returns to IDLE.

Top module: `s2m_write_engine`

## Requirements
- R1: `cmd_ready` is high only in IDLE, and a command is taken when `cmd_valid` and `cmd_ready` are both high. The low six bits of `cmd_addr` are forced to zero. Each write address is the aligned command address plus 64 times the beat index.
- R2: Every accepted beat produces exactly one write. `wr_writedata` equals `snk_data`, with stream byte i on bits [8i+7:8i].
- R3: On a beat with `snk_eop` high, `snk_empty` = E marks the top E byte lanes as unused. Only lanes 0 to 63-E are enabled, and 64-E bytes are added to the byte count. Beats without EOP count 64 bytes, all lanes enabled.
- R4: With `cmd_stop_on_eop` = 1, the beat that carries EOP ends the transfer. `snk_ready` stays low from then until the next command.
- R5: With `cmd_stop_on_eop` = 0, EOP does not end the transfer. Beats keep being accepted until the byte limit is reached. `done_eop_seen` still reports that an EOP beat was taken.
- R6: If the limit falls inside a beat, only the lanes below the limit are enabled and the count stops exactly at the limit. `snk_ready` stays low afterwards.
- R7: While `wr_waitrequest` is high, `wr_write`, `wr_address`, `wr_byteenable` and `wr_writedata` hold their values.
- R8: No more than MAX_OUTSTANDING writes may be issued without a response. At that limit `snk_ready` is low.
- R9: `done_valid` is a one-cycle pulse. It is raised only after the response for every issued write has come back. `done_bytes` and `done_eop_seen` are valid with it.
- R10: A command with a zero limit completes with `done_bytes` = 0 and `done_eop_seen` = 0, and accepts no beat.
- R11: After reset, `cmd_ready` is 1 and `snk_ready`, `wr_write` and `done_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken |
| cmd_addr | input | ADDR_W | Destination byte address (64-byte aligned) |
| cmd_max_bytes | input | CNT_W | Byte limit |
| cmd_stop_on_eop | input | 1 | End transfer at first EOP |
| snk_valid | input | 1 | Stream beat valid |
| snk_ready | output | 1 | Stream beat accepted |
| snk_data | input | DATA_W | Beat payload |
| snk_sop | input | 1 | Start-of-packet marker |
| snk_eop | input | 1 | End-of-packet marker |
| snk_empty | input | log2(DATA_W/8) | Unused top lanes on an EOP beat |
| wr_write | output | 1 | Memory write request |
| wr_waitrequest | input | 1 | Memory stall |
| wr_address | output | ADDR_W | Write byte address |
| wr_writedata | output | DATA_W | Write data |
| wr_byteenable | output | DATA_W/8 | Lane enables |
| wr_response_valid | input | 1 | One write response returned |
| done_valid | output | 1 | Completion pulse |
| done_bytes | output | CNT_W | Bytes stored |
| done_eop_seen | output | 1 | An EOP beat was taken |

## Verification
The hardest condition to reach is the response limit being hit while writes are also being stalled. The stimulus holds back all responses from memory and toggles the stall signal every cycle. It then offers more beats than the limit allows and checks that the extra beat is refused. When responses are released, the transfer must finish, and the completion pulse must appear only once the memory model has no responses left to give.

// File: rtl/s2m_pkg.sv
package s2m_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_FLUSH,
        ST_REPORT
    } s2m_state_e;
endpackage

// File: rtl/s2m_beat_trim.sv
module s2m_beat_trim #(
    parameter int BYTES = 64,
    parameter int CNT_W = 32,
    localparam int EMPTY_W = $clog2(BYTES),
    localparam int TAKE_W = $clog2(BYTES + 1)
) (
    input  logic               eop,
    input  logic [EMPTY_W-1:0] empty,
    input  logic [CNT_W-1:0]   remaining,
    output logic [TAKE_W-1:0]  take,
    output logic [BYTES-1:0]   lane_en,
    output logic               hits_limit
);
    logic [TAKE_W-1:0] beat_bytes;
    logic [CNT_W-1:0]  beat_wide;

    always_comb begin
        beat_bytes = eop ? TAKE_W'(BYTES) - TAKE_W'(empty) : TAKE_W'(BYTES);
        beat_wide  = CNT_W'(beat_bytes);
        if (remaining < beat_wide) begin
            take = TAKE_W'(remaining);
        end else begin
            take = beat_bytes;
        end
        hits_limit = (remaining <= beat_wide);
    end

    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        assign lane_en[i] = (TAKE_W'(i) < take);
    end
endmodule

// File: rtl/s2m_resp_tracker.sv
module s2m_resp_tracker #(
    parameter int MAX_OUTSTANDING = 4,
    localparam int CW = $clog2(MAX_OUTSTANDING + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic          retire,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          none
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case ({issue, retire})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign full = (count == CW'(MAX_OUTSTANDING));
    assign none = (count == '0);
endmodule

// File: rtl/s2m_write_engine.sv
module s2m_write_engine #(
    parameter int DATA_W = 512,
    parameter int ADDR_W = 48,
    parameter int CNT_W = 32,
    parameter int MAX_OUTSTANDING = 4,
    localparam int BYTES = DATA_W / 8,
    localparam int EMPTY_W = $clog2(BYTES),
    localparam int TAKE_W = $clog2(BYTES + 1),
    localparam int OCW = $clog2(MAX_OUTSTANDING + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic [CNT_W-1:0]   cmd_max_bytes,
    input  logic               cmd_stop_on_eop,
    input  logic               snk_valid,
    output logic               snk_ready,
    input  logic [DATA_W-1:0]  snk_data,
    input  logic               snk_sop,
    input  logic               snk_eop,
    input  logic [EMPTY_W-1:0] snk_empty,
    output logic               wr_write,
    input  logic               wr_waitrequest,
    output logic [ADDR_W-1:0]  wr_address,
    output logic [DATA_W-1:0]  wr_writedata,
    output logic [BYTES-1:0]   wr_byteenable,
    input  logic               wr_response_valid,
    output logic               done_valid,
    output logic [CNT_W-1:0]   done_bytes,
    output logic               done_eop_seen
);
    import s2m_pkg::*;

    localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(BYTES - 1);

    s2m_state_e        state, state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;
    logic [CNT_W-1:0]  bytes_q;
    logic              eop_seen_q;
    logic              stop_q;
    logic              accept;
    logic              slot_free;
    logic              ends_here;
    logic [TAKE_W-1:0] take;
    logic [BYTES-1:0]  lane_en;
    logic              hits_limit;
    logic [OCW-1:0]    outst_cnt;
    logic              outst_full;
    logic              outst_none;
    logic              sop_unused;

    assign sop_unused = snk_sop;

    s2m_beat_trim #(.BYTES(BYTES), .CNT_W(CNT_W)) u_trim (
        .eop        (snk_eop),
        .empty      (snk_empty),
        .remaining  (left_q),
        .take       (take),
        .lane_en    (lane_en),
        .hits_limit (hits_limit)
    );

    s2m_resp_tracker #(.MAX_OUTSTANDING(MAX_OUTSTANDING)) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .issue  (accept),
        .retire (wr_response_valid),
        .count  (outst_cnt),
        .full   (outst_full),
        .none   (outst_none)
    );

    assign slot_free = !wr_write || !wr_waitrequest;
    assign accept    = snk_valid && snk_ready;
    assign ends_here = hits_limit || (stop_q && snk_eop);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    state_nx = (cmd_max_bytes == '0) ? ST_FLUSH : ST_XFER;
                end
            end
            ST_XFER: begin
                if (accept && ends_here) begin
                    state_nx = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                if (!wr_write && outst_none) begin
                    state_nx = ST_REPORT;
                end
            end
            ST_REPORT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        cmd_ready  = (state == ST_IDLE);
        snk_ready  = (state == ST_XFER) && slot_free && !outst_full;
        done_valid = (state == ST_REPORT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            left_q     <= '0;
            bytes_q    <= '0;
            eop_seen_q <= 1'b0;
            stop_q     <= 1'b0;
        end else if (cmd_valid && cmd_ready) begin
            addr_q     <= cmd_addr & ~ALIGN_MASK;
            left_q     <= cmd_max_bytes;
            bytes_q    <= '0;
            eop_seen_q <= 1'b0;
            stop_q     <= cmd_stop_on_eop;
        end else if (accept) begin
            addr_q     <= addr_q + ADDR_W'(BYTES);
            left_q     <= left_q - CNT_W'(take);
            bytes_q    <= bytes_q + CNT_W'(take);
            eop_seen_q <= eop_seen_q | snk_eop;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_write      <= 1'b0;
            wr_address    <= '0;
            wr_writedata  <= '0;
            wr_byteenable <= '0;
        end else if (accept) begin
            wr_write      <= 1'b1;
            wr_address    <= addr_q;
            wr_writedata  <= snk_data;
            wr_byteenable <= lane_en;
        end else if (!wr_waitrequest) begin
            wr_write      <= 1'b0;
        end
    end

    assign done_bytes    = bytes_q;
    assign done_eop_seen = eop_seen_q;
endmodule

// File: rtl/s2m_write_engine_chk.sv
module s2m_write_engine_chk #(
    parameter int DATA_W = 512,
    parameter int ADDR_W = 48,
    parameter int MAX_OUTSTANDING = 4,
    localparam int BYTES = DATA_W / 8,
    localparam int OCW = $clog2(MAX_OUTSTANDING + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              snk_ready,
    input logic              wr_write,
    input logic              wr_waitrequest,
    input logic [ADDR_W-1:0] wr_address,
    input logic [DATA_W-1:0] wr_writedata,
    input logic [BYTES-1:0]  wr_byteenable,
    input logic              done_valid,
    input logic [OCW-1:0]    outst_cnt
);
    p_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_write |-> (wr_address[$clog2(BYTES)-1:0] == '0));

    p_lanes_contig_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_write |-> (wr_byteenable[0] && ((wr_byteenable & (wr_byteenable + BYTES'(1))) == '0)));

    p_ready_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        snk_ready |-> !cmd_ready);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_write && wr_waitrequest) |=> (wr_write && $stable(wr_address)
            && $stable(wr_byteenable) && $stable(wr_writedata)));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        outst_cnt <= OCW'(MAX_OUTSTANDING));

    p_done_drained_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (outst_cnt == '0 && !wr_write));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);
endmodule

bind s2m_write_engine s2m_write_engine_chk #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .MAX_OUTSTANDING(MAX_OUTSTANDING)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_ready      (cmd_ready),
    .snk_ready      (snk_ready),
    .wr_write       (wr_write),
    .wr_waitrequest (wr_waitrequest),
    .wr_address     (wr_address),
    .wr_writedata   (wr_writedata),
    .wr_byteenable  (wr_byteenable),
    .done_valid     (done_valid),
    .outst_cnt      (outst_cnt)
);

// File: tb/tb_s2m_write_engine.sv
`timescale 1ns/1ps
module tb_s2m_write_engine;
    localparam int DATA_W = 512;
    localparam int ADDR_W = 48;
    localparam int CNT_W = 32;
    localparam int MAXO = 4;
    localparam int BYTES = DATA_W / 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [CNT_W-1:0]  cmd_max_bytes = '0;
    logic              cmd_stop_on_eop = 1'b0;
    logic              snk_valid = 1'b0;
    logic              snk_ready;
    logic [DATA_W-1:0] snk_data = '0;
    logic              snk_sop = 1'b0;
    logic              snk_eop = 1'b0;
    logic [5:0]        snk_empty = '0;
    logic              wr_write;
    logic              wr_waitrequest = 1'b0;
    logic [ADDR_W-1:0] wr_address;
    logic [DATA_W-1:0] wr_writedata;
    logic [BYTES-1:0]  wr_byteenable;
    logic              wr_response_valid = 1'b0;
    logic              done_valid;
    logic [CNT_W-1:0]  done_bytes;
    logic              done_eop_seen;

    int errors = 0;
    int checks = 0;
    int nrec = 0;
    int pend = 0;
    int done_cnt = 0;
    int pend_at_done = 0;
    logic [CNT_W-1:0]  last_bytes;
    logic              last_eop;
    logic              resp_en = 1'b1;
    logic              stall_toggle = 1'b0;
    logic [ADDR_W-1:0] rec_addr [64];
    logic [DATA_W-1:0] rec_data [64];
    logic [BYTES-1:0]  rec_be [64];

    s2m_write_engine #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_OUTSTANDING(MAXO)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_max_bytes(cmd_max_bytes), .cmd_stop_on_eop(cmd_stop_on_eop),
        .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_data(snk_data),
        .snk_sop(snk_sop), .snk_eop(snk_eop), .snk_empty(snk_empty),
        .wr_write(wr_write), .wr_waitrequest(wr_waitrequest), .wr_address(wr_address),
        .wr_writedata(wr_writedata), .wr_byteenable(wr_byteenable),
        .wr_response_valid(wr_response_valid),
        .done_valid(done_valid), .done_bytes(done_bytes), .done_eop_seen(done_eop_seen)
    );

    always #2 clk = ~clk;

    // memory model and completion monitor, updated away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (resp_en && pend > 0) begin
                wr_response_valid <= 1'b1;
                pend = pend - 1;
            end else begin
                wr_response_valid <= 1'b0;
            end
            if (stall_toggle) wr_waitrequest = ~wr_waitrequest;
            else wr_waitrequest = 1'b0;
            if (wr_write && !wr_waitrequest && nrec < 64) begin
                rec_addr[nrec] = wr_address;
                rec_data[nrec] = wr_writedata;
                rec_be[nrec] = wr_byteenable;
                nrec = nrec + 1;
                pend = pend + 1;
            end
            if (done_valid) begin
                done_cnt = done_cnt + 1;
                last_bytes = done_bytes;
                last_eop = done_eop_seen;
                pend_at_done = pend;
            end
        end
    end

    function automatic logic [BYTES-1:0] mask(input int n);
        if (n >= BYTES) return '1;
        return (BYTES'(1) << n) - BYTES'(1);
    endfunction

    function automatic logic [DATA_W-1:0] mkdata(input int k);
        return {16{32'hA500_0000 + 32'(k)}};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [ADDR_W-1:0] a, input int maxb, input logic stop);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_addr = a;
        cmd_max_bytes = CNT_W'(maxb);
        cmd_stop_on_eop = stop;
        #1;
        while (!cmd_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic push(input int k, input logic eop, input int empty, input int tries,
                        output logic taken);
        @(negedge clk);
        snk_valid = 1'b1;
        snk_data = mkdata(k);
        snk_sop = (k == 0);
        snk_eop = eop;
        snk_empty = 6'(empty);
        taken = 1'b0;
        for (int t = 0; t < tries; t++) begin
            #1;
            if (snk_ready) begin
                taken = 1'b1;
                break;
            end
            @(negedge clk);
        end
        if (taken) @(posedge clk);
        @(negedge clk);
        snk_valid = 1'b0;
        snk_eop = 1'b0;
    endtask

    task automatic wait_done(input int prev);
        for (int t = 0; t < 300; t++) begin
            if (done_cnt != prev) break;
            @(negedge clk);
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        #1;
        check("R11 cmd_ready", 64'(cmd_ready), 64'd1);
        check("R11 snk_ready", 64'(snk_ready), 64'd0);
        check("R11 wr_write", 64'(wr_write), 64'd0);
        check("R11 done_valid", 64'(done_valid), 64'd0);
    endtask

    task automatic t_basic_eop;
        logic tk;
        int r0 = nrec;
        int d0 = done_cnt;
        issue(48'h1000_0065, 256, 1'b1);
        check("R1 busy cmd_ready", 64'(cmd_ready), 64'd0);
        push(0, 1'b0, 0, 20, tk);
        push(1, 1'b0, 0, 20, tk);
        push(2, 1'b1, 10, 20, tk);
        push(3, 1'b0, 0, 6, tk);
        check("R4 refused after eop", 64'(tk), 64'd0);
        wait_done(d0);
        check("R2 write count", 64'(nrec - r0), 64'd3);
        check("R1 addr0", 64'(rec_addr[r0]), 64'h1000_0040);
        check("R1 addr2", 64'(rec_addr[r0 + 2]), 64'h1000_00C0);
        check("R2 data lanes", 64'(rec_data[r0 + 1] == mkdata(1)), 64'd1);
        check("R2 data high", 64'(rec_data[r0 + 2][DATA_W-1 -: 32]), 64'hA500_0002);
        check("R3 full lanes", 64'(rec_be[r0]), 64'(mask(64)));
        check("R3 empty lanes", 64'(rec_be[r0 + 2]), 64'(mask(54)));
        check("R3 bytes", 64'(last_bytes), 64'd182);
        check("R4 eop flag", 64'(last_eop), 64'd1);
    endtask

    task automatic t_eop_ignored;
        logic tk;
        int r0 = nrec;
        int d0 = done_cnt;
        issue(48'h2000, 192, 1'b0);
        push(0, 1'b0, 0, 20, tk);
        push(1, 1'b1, 0, 20, tk);
        push(2, 1'b0, 0, 20, tk);
        check("R5 beat after eop taken", 64'(tk), 64'd1);
        push(3, 1'b0, 0, 6, tk);
        check("R5 refused at limit", 64'(tk), 64'd0);
        wait_done(d0);
        check("R5 writes", 64'(nrec - r0), 64'd3);
        check("R5 bytes", 64'(last_bytes), 64'd192);
        check("R5 eop seen", 64'(last_eop), 64'd1);
    endtask

    task automatic t_mid_beat;
        logic tk;
        int r0 = nrec;
        int d0 = done_cnt;
        issue(48'h3000, 100, 1'b1);
        push(0, 1'b0, 0, 20, tk);
        push(1, 1'b0, 0, 20, tk);
        push(2, 1'b0, 0, 6, tk);
        check("R6 refused after limit", 64'(tk), 64'd0);
        wait_done(d0);
        check("R6 writes", 64'(nrec - r0), 64'd2);
        check("R6 partial lanes", 64'(rec_be[r0 + 1]), 64'(mask(36)));
        check("R6 bytes", 64'(last_bytes), 64'd100);
        check("R6 no eop", 64'(last_eop), 64'd0);
    endtask

    task automatic t_backpressure;
        logic tk;
        int r0 = nrec;
        int d0 = done_cnt;
        resp_en = 1'b0;
        stall_toggle = 1'b1;
        issue(48'h4000, 512, 1'b0);
        for (int k = 0; k < MAXO; k++) push(k, 1'b0, 0, 20, tk);
        push(MAXO, 1'b0, 0, 20, tk);
        check("R8 refused at limit", 64'(tk), 64'd0);
        check("R7 writes under stall", 64'(nrec - r0), 64'(MAXO));
        resp_en = 1'b1;
        push(MAXO, 1'b0, 0, 40, tk);
        check("R8 resumes", 64'(tk), 64'd1);
        for (int k = MAXO + 1; k < 8; k++) push(k, 1'b0, 0, 40, tk);
        resp_en = 1'b0;
        repeat (20) @(negedge clk);
        check("R9 held without responses", 64'(done_cnt - d0), 64'd0);
        resp_en = 1'b1;
        wait_done(d0);
        stall_toggle = 1'b0;
        check("R9 one pulse", 64'(done_cnt - d0), 64'd1);
        check("R9 drained at done", 64'(pend_at_done), 64'd0);
        check("R9 bytes", 64'(last_bytes), 64'd512);
        check("R7 writes total", 64'(nrec - r0), 64'd8);
        check("R7 last addr", 64'(rec_addr[r0 + 7]), 64'h41C0);
    endtask

    task automatic t_zero;
        logic tk;
        int r0 = nrec;
        int d0 = done_cnt;
        issue(48'h5000, 0, 1'b1);
        push(0, 1'b0, 0, 4, tk);
        wait_done(d0);
        check("R10 no beat", 64'(tk), 64'd0);
        check("R10 done", 64'(done_cnt - d0), 64'd1);
        check("R10 bytes", 64'(last_bytes), 64'd0);
        check("R10 eop", 64'(last_eop), 64'd0);
        check("R10 no writes", 64'(nrec - r0), 64'd0);
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_basic_eop();
        t_eop_ignored();
        t_mid_beat();
        t_backpressure();
        t_zero();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule